// File: doc/BRIEF.md
# External Bus Ownership Arbiter

This block decides who drives the shared system bus: the on-chip processor side or a single external master. The external master asks for the bus on an active-low request pin. The block answers with an active-low grant. It waits for a gap between internal bus operations before it grants, so a burst is never split. An active-low hold pin from the external master confirms that it now has the bus. When the internal side needs the bus back, the block raises an active-low reclaim output. That output stays up until the external master withdraws its request.

The block also drives one output-enable for the internal side's address, byte-enable, start, last and read/write pads. The enable goes low on the same clock edge as the grant. It comes back a programmable number of clocks after the grant is removed, so the two masters never drive the bus at the same time. The two pins from the external master are passed through a synchronizer of selectable depth before any decision uses them. The external master's own bus-cycle timing is handled elsewhere.

Top module: `bus_own_arb`

## Requirements
- R1: After reset `grant_n` and `reclaim_n` are high (inactive) and `pads_oe` is high (internal pads driving).
- R2: With `int_busy` low, a request held low on `ext_req_n` drives `grant_n` low on the (SYNC_STAGES+1)-th rising edge after it is first sampled, and not earlier.
- R3: While `int_busy` is high no grant is issued. Once `int_busy` drops with the request already synchronized, `grant_n` goes low on the next rising edge.
- R4: `pads_oe` goes low on the same edge that `grant_n` goes low, and stays low for as long as `grant_n` is low.
- R5: `pads_oe` returns high exactly TURN_CYCLES rising edges after the edge on which `grant_n` returns high (1 by default).
- R6: `reclaim_n` is low only while `grant_n` is low. An `int_want` with no external owner produces no reclaim.
- R7: Once low, `reclaim_n` stays low even if `int_want` drops. It returns high on the same edge as `grant_n`, when the synchronized request goes inactive.
- R8: `grant_n` returns high on the (SYNC_STAGES+1)-th rising edge after `ext_req_n` goes high. This holds whether or not `ext_hold_n` was ever asserted.
- R9: `reclaim_n` is not asserted before the external master shows ownership on `ext_hold_n`. With `int_want` high, it falls on the (SYNC_STAGES+1)-th edge after `ext_hold_n` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req_n | input | 1 | External master bus request, active low, asynchronous |
| ext_hold_n | input | 1 | External master holds the bus, active low, asynchronous |
| int_busy | input | 1 | Internal side is inside a bus operation or burst |
| int_want | input | 1 | Internal side needs the bus |
| grant_n | output | 1 | Bus granted to external master, active low |
| reclaim_n | output | 1 | Asks the external master to return the bus, active low |
| pads_oe | output | 1 | Enable for internal address/byte-enable/start/last/read-write drivers |

## Verification
The hardest state to reach is a grant that is live while the external master has not yet shown ownership and the internal side already wants the bus back. In that state reclaim must wait for the hold pin, and after that it must stay set through a withdrawn `int_want`. The bench gets there by raising `int_want` right after the grant while keeping `ext_hold_n` high. It then lowers the hold pin and counts synchronizer edges, drops `int_want`, and only at the end withdraws the request. In this way the reclaim timing, the sticky reclaim and its release together with the grant are each observed at fixed edges.

// File: rtl/bus_own_pkg.sv
package bus_own_pkg;

    typedef enum logic [1:0] {
        OWN_INT  = 2'd0,
        OWN_GNT  = 2'd1,
        OWN_EXT  = 2'd2
    } own_state_e;

    typedef struct packed {
        own_state_e st;
        logic       grant;
        logic       reclaim;
    } own_regs_t;

    localparam own_regs_t OWN_RESET = '{st: OWN_INT, grant: 1'b0, reclaim: 1'b0};

endpackage

// File: rtl/bus_own_sync.sv
module bus_own_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] INIT = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int NS = (STAGES < 1) ? 1 : STAGES;

    logic [WIDTH-1:0] chain_q [NS];
    logic [WIDTH-1:0] chain_d [NS];

    genvar s;
    generate
        for (s = 0; s < NS; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb chain_d[s] = din;
            end else begin : g_next
                always_comb chain_d[s] = chain_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= INIT;
                else        chain_q[s] <= chain_d[s];
            end
        end
    endgenerate

    assign dout = chain_q[NS-1];
endmodule

// File: rtl/bus_own_fsm.sv
module bus_own_fsm
    import bus_own_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_s,
    input  logic hold_s,
    input  logic int_busy,
    input  logic int_want,
    output logic grant_next,
    output logic grant_q,
    output logic reclaim_q
);
    own_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            OWN_INT: begin
                if (req_s && !int_busy) begin
                    r_d.st    = OWN_GNT;
                    r_d.grant = 1'b1;
                end
            end
            OWN_GNT, OWN_EXT: begin
                if (!req_s) begin
                    r_d.st      = OWN_INT;
                    r_d.grant   = 1'b0;
                    r_d.reclaim = 1'b0;
                end else if (hold_s) begin
                    r_d.st = OWN_EXT;
                end
            end
            default: r_d = OWN_RESET;
        endcase
        if (r_q.grant && r_d.grant && hold_s && int_want)
            r_d.reclaim = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= OWN_RESET;
        else        r_q <= r_d;
    end

    assign grant_next = r_d.grant;
    assign grant_q    = r_q.grant;
    assign reclaim_q  = r_q.reclaim;

    // R3
    grant_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.grant) |-> !$past(int_busy));
    // R6
    reclaim_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.reclaim |-> r_q.grant);
    // R7
    reclaim_drops_with_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.reclaim) |-> $fell(r_q.grant));
    // R9
    reclaim_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.reclaim) |-> $past(hold_s));
endmodule

// File: rtl/bus_own_oe.sv
module bus_own_oe #(
    parameter int TURN_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant_next,
    input  logic grant_q,
    output logic oe_q
);
    localparam int TC = (TURN_CYCLES < 1) ? 1 : TURN_CYCLES;
    localparam int CW = $clog2(TC + 1);

    typedef struct packed {
        logic          oe;
        logic [CW-1:0] cnt;
    } oe_regs_t;

    oe_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (grant_next) begin
            r_d.oe  = 1'b0;
            r_d.cnt = CW'(TC);
        end else if (r_q.cnt != '0) begin
            r_d.oe  = 1'b0;
            r_d.cnt = r_q.cnt - 1'b1;
        end else begin
            r_d.oe  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{oe: 1'b1, cnt: '0};
        else        r_q <= r_d;
    end

    assign oe_q = r_q.oe;

    // R5
    oe_turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.oe) |-> !grant_q && !$past(grant_q));
endmodule

// File: rtl/bus_own_arb.sv
module bus_own_arb #(
    parameter int SYNC_STAGES = 2,
    parameter int TURN_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_req_n,
    input  logic ext_hold_n,
    input  logic int_busy,
    input  logic int_want,
    output logic grant_n,
    output logic reclaim_n,
    output logic pads_oe
);
    logic [1:0] pins_s;
    logic       grant_next, grant_q, reclaim_q, oe_q;

    bus_own_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .INIT(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ext_hold_n, ext_req_n}),
        .dout  (pins_s)
    );

    bus_own_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_s      (~pins_s[0]),
        .hold_s     (~pins_s[1]),
        .int_busy   (int_busy),
        .int_want   (int_want),
        .grant_next (grant_next),
        .grant_q    (grant_q),
        .reclaim_q  (reclaim_q)
    );

    bus_own_oe #(.TURN_CYCLES(TURN_CYCLES)) u_oe (
        .clk        (clk),
        .rst_n      (rst_n),
        .grant_next (grant_next),
        .grant_q    (grant_q),
        .oe_q       (oe_q)
    );

    assign grant_n   = ~grant_q;
    assign reclaim_n = ~reclaim_q;
    assign pads_oe   = oe_q;

    // R4
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_n |-> !pads_oe);
    // R6
    reclaim_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reclaim_n |-> !grant_n);
endmodule

// File: tb/bus_own_arb_test.sv
module bus_own_arb_test;
    localparam int SYNC = 2;
    localparam int TURN = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_n = 1'b1, hold_n = 1'b1, busy = 1'b0, want = 1'b0;
    logic grant_n, reclaim_n, pads_oe;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    bus_own_arb #(.SYNC_STAGES(SYNC), .TURN_CYCLES(TURN)) uut (
        .clk(clk), .rst_n(rst_n), .ext_req_n(req_n), .ext_hold_n(hold_n),
        .int_busy(busy), .int_want(want),
        .grant_n(grant_n), .reclaim_n(reclaim_n), .pads_oe(pads_oe)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        step(2);
        rst_n = 1'b1;
        step(1);
        chk("R1 grant_n after reset", grant_n, 1'b1);
        chk("R1 reclaim_n after reset", reclaim_n, 1'b1);
        chk("R1 pads_oe after reset", pads_oe, 1'b1);
    endtask

    task automatic t_grant_and_return;
        req_n = 1'b0;
        step(SYNC);
        chk("R2 no early grant", grant_n, 1'b1);
        chk("R4 pads still on before grant", pads_oe, 1'b1);
        step(1);
        chk("R2 grant latency", grant_n, 1'b0);
        chk("R4 pads off with grant", pads_oe, 1'b0);
        hold_n = 1'b0;
        step(4);
        chk("R4 pads off while granted", pads_oe, 1'b0);
        chk("R6 no reclaim without want", reclaim_n, 1'b1);
        req_n = 1'b1; hold_n = 1'b1;
        step(SYNC);
        chk("R8 grant held until sync", grant_n, 1'b0);
        step(1);
        chk("R8 grant removed", grant_n, 1'b1);
        chk("R5 pads still off at turnaround", pads_oe, 1'b0);
        step(TURN);
        chk("R5 pads back on", pads_oe, 1'b1);
        step(4);
    endtask

    task automatic t_busy_defer;
        busy = 1'b1;
        req_n = 1'b0;
        step(SYNC + 4);
        chk("R3 no grant while busy", grant_n, 1'b1);
        chk("R3 pads on while busy", pads_oe, 1'b1);
        busy = 1'b0;
        step(1);
        chk("R3 grant after busy drops", grant_n, 1'b0);
        req_n = 1'b1;
        step(SYNC + 1 + TURN);
        chk("R8 grant removed after busy test", grant_n, 1'b1);
        step(4);
    endtask

    task automatic t_reclaim;
        req_n = 1'b0;
        step(SYNC + 1);
        chk("R2 grant for reclaim test", grant_n, 1'b0);
        want = 1'b1;
        step(SYNC + 2);
        chk("R9 no reclaim before hold", reclaim_n, 1'b1);
        hold_n = 1'b0;
        step(SYNC);
        chk("R9 reclaim not yet", reclaim_n, 1'b1);
        step(1);
        chk("R9 reclaim after hold", reclaim_n, 1'b0);
        chk("R6 grant still on with reclaim", grant_n, 1'b0);
        want = 1'b0;
        step(3);
        chk("R7 reclaim sticky after want drops", reclaim_n, 1'b0);
        req_n = 1'b1; hold_n = 1'b1;
        step(SYNC);
        chk("R7 reclaim held until request syncs", reclaim_n, 1'b0);
        step(1);
        chk("R7 reclaim clears", reclaim_n, 1'b1);
        chk("R7 grant clears with reclaim", grant_n, 1'b1);
        step(TURN + 4);
    endtask

    task automatic t_internal_want;
        want = 1'b1;
        step(4);
        chk("R6 no reclaim when internal owns", reclaim_n, 1'b1);
        chk("R6 pads on when internal owns", pads_oe, 1'b1);
        want = 1'b0;
        step(1);
    endtask

    task automatic t_abandon;
        req_n = 1'b0;
        step(SYNC + 1);
        chk("R2 grant for abandon test", grant_n, 1'b0);
        req_n = 1'b1;
        step(SYNC + 1);
        chk("R8 grant withdrawn without hold", grant_n, 1'b1);
        chk("R5 pads off right after withdraw", pads_oe, 1'b0);
        step(TURN);
        chk("R5 pads on after withdraw", pads_oe, 1'b1);
        step(4);
    endtask

    initial begin
        t_reset;
        t_grant_and_return;
        t_busy_defer;
        t_reclaim;
        t_internal_want;
        t_abandon;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule